// File: doc/BRIEF.md
# Two-Wire Register Target with Auto-Advancing Pointer

This block is a target on a two-wire serial bus (I2C). A bus controller reaches six byte-wide registers through it. The registers are a read-only view of two input pins, a divider byte and a duty byte for each of two blink channels, and one byte that selects the LED source. The block runs entirely on a fast system clock. It oversamples the serial clock and data lines, finds START and STOP conditions, matches its 7-bit address, acknowledges bytes and moves data between the bus and the registers.

Every write transaction begins with a command byte. The command byte holds a 3-bit register pointer and a flag that makes the pointer advance after each register access. The stored register values drive the rest of the chip directly through output ports. The serial data line is open-drain: the block only reports when it wants the line pulled low.

Top module: `i2cRegBank`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 110000 followed by the `addrPin` level. Bit 0 of that byte selects the direction: 1 is a read, 0 is a write. On a mismatch it does not pull SDA during the ninth clock, and it ignores all further bytes until the next START.
- R2: In a write, the first byte after an acknowledged address loads the command state. Bits 2:0 become the register pointer and bit 4 becomes the auto-advance flag. This byte is acknowledged and changes no register output.
- R3: Each later write byte is acknowledged and stored at the pointer. The map is: pointer 1 drives `prescale0`, 2 drives `duty0`, 3 drives `prescale1`, 4 drives `duty1` and 5 drives `ledSelect`.
- R4: When the auto-advance flag is 1, the pointer steps by one after every register byte written or read. From 5, 6 or 7 it goes to 0. When the flag is 0, the pointer stays where it is.
- R5: A read returns the byte at the pointer, most significant bit first. Pointer 0 returns `{6'b0, pinsIn}` as sampled. Pointers 1 to 5 return the stored bytes. Pointers 6 and 7 return 00h.
- R6: Writes while the pointer is 0, 6 or 7 leave every register output unchanged.
- R7: When the controller does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R8: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP releases SDA and returns the block to idle. A START, including a repeated START, always restarts address reception.
- R9: While `rstN` is low, all register outputs are 00h, the pointer and flag are 0, and SDA is released. Everything stays that way until `rstN` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 20 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| addrPin | input | 1 | Sets address bit 0 |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | High when the block pulls SDA low |
| pinsIn | input | 2 | Input pins visible at pointer 0 |
| prescale0 | output | 8 | Channel 0 divider byte |
| duty0 | output | 8 | Channel 0 duty byte |
| prescale1 | output | 8 | Channel 1 divider byte |
| duty1 | output | 8 | Channel 1 duty byte |
| ledSelect | output | 8 | LED source selector byte |

## Verification
A corrupted pointer or command state shows up one byte later. The next write lands on the wrong output port, or the next read returns the wrong byte, so every multi-byte transfer exposes it within nine SCL periods. A bit-counter or state error appears on SDA. The block acknowledges at the wrong clock or fails to, or it drives while the controller owns the line, and this is visible in the same SCL high phase. For that reason the SDA pull and all five register outputs are compared against a model on every system clock while SCL is high.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              cmdWr;
    logic              regWr;
    logic              rdDone;
    logic [BYTE_W-1:0] data;
  } busStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WR_ACK,
    ST_READ,
    ST_RD_ACK
  } busState_t;
endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cRegPkg::*;
#(
  parameter int          ADDR_HI_W = 6,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 6'b110000,
  parameter int          SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrPin,
  input  logic [BYTE_W-1:0] rdData,
  output busStrobe_t        strb,
  output logic              sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [SYNC_DEPTH-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;

  busState_t         state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              firstByte, rwBit, masterAck, sdaPull;

  // line synchronizers; reset to the idle-high bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_DEPTH-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_DEPTH-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_DEPTH-1];
  assign sdaS      = sdaSync[SYNC_DEPTH-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      firstByte <= 1'b0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
      sdaPull   <= 1'b0;
      strb      <= '0;
    end else begin
      strb <= '0;
      if (startSeen) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        sdaPull <= 1'b0;
      end else if (stopSeen) begin
        state   <= ST_IDLE;
        sdaPull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WRITE: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              if (state == ST_ADDR) begin
                if (shiftReg[BYTE_W-1:1] == {ADDR_HI, addrPin}) begin
                  rwBit   <= shiftReg[0];
                  sdaPull <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                strb.data <= shiftReg;
                if (firstByte) strb.cmdWr <= 1'b1;
                else           strb.regWr <= 1'b1;
                firstByte <= 1'b0;
                sdaPull   <= 1'b1;
                state     <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rwBit) begin
                state    <= ST_READ;
                shiftReg <= rdData;
                sdaPull  <= ~rdData[BYTE_W-1];
              end else begin
                state     <= ST_WRITE;
                firstByte <= 1'b1;
                sdaPull   <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (sclFall) begin
              sdaPull <= 1'b0;
              bitCnt  <= '0;
              state   <= ST_WRITE;
            end
          end
          ST_READ: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaPull     <= 1'b0;
                strb.rdDone <= 1'b1;
                state       <= ST_RD_ACK;
              end else begin
                shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
                sdaPull  <= ~shiftReg[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                state    <= ST_READ;
                bitCnt   <= '0;
                shiftReg <= rdData;
                sdaPull  <= ~rdData[BYTE_W-1];
              end else begin
                state   <= ST_IDLE;
                sdaPull <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaPullLow = sdaPull;
endmodule

// File: rtl/i2cRegFile.sv
module i2cRegFile
  import i2cRegPkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int NUM_REGS = 6,
  parameter int PTR_W    = 3,
  parameter int AI_BIT   = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  busStrobe_t                           strb,
  input  logic [NUM_PINS-1:0]                  pinsIn,
  output logic [BYTE_W-1:0]                    rdData,
  output logic [NUM_REGS-1:1][BYTE_W-1:0]      regsOut,
  output logic [PTR_W-1:0]                     ptrCur,
  output logic                                 aiCur
);
  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);

  logic [NUM_PINS-1:0] pinMeta, pinSync;
  logic [PTR_W-1:0]    ptr;
  logic                ai;
  logic [BYTE_W-1:0]   regQ [1:NUM_REGS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= '0;
      pinSync <= '0;
    end else begin
      pinMeta <= pinsIn;
      pinSync <= pinMeta;
    end
  end

  // pointer and auto-advance flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      ai  <= 1'b0;
    end else if (strb.cmdWr) begin
      ptr <= strb.data[PTR_W-1:0];
      ai  <= strb.data[AI_BIT];
    end else if ((strb.regWr || strb.rdDone) && ai) begin
      ptr <= (ptr >= LAST_REG) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   regQ[g] <= '0;
      else if (strb.regWr && ptr == PTR_W'(g))     regQ[g] <= strb.data;
    end
    assign regsOut[g] = regQ[g];
  end

  always_comb begin
    rdData = '0;
    if (ptr == '0) rdData = {{(BYTE_W-NUM_PINS){1'b0}}, pinSync};
    for (int k = 1; k < NUM_REGS; k++) begin
      if (ptr == PTR_W'(k)) rdData = regQ[k];
    end
  end

  assign ptrCur = ptr;
  assign aiCur  = ai;
endmodule

// File: rtl/i2cRegBank.sv
module i2cRegBank
  import i2cRegPkg::*;
#(
  parameter logic [5:0] ADDR_HI  = 6'b110000,
  parameter int         NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                addrPin,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaPullLow,
  input  logic [NUM_PINS-1:0] pinsIn,
  output logic [BYTE_W-1:0]   prescale0,
  output logic [BYTE_W-1:0]   duty0,
  output logic [BYTE_W-1:0]   prescale1,
  output logic [BYTE_W-1:0]   duty1,
  output logic [BYTE_W-1:0]   ledSelect
);
  localparam int NUM_REGS = 6;
  localparam int PTR_W    = 3;

  busStrobe_t                         strb;
  logic [BYTE_W-1:0]                  rdData;
  logic [NUM_REGS-1:1][BYTE_W-1:0]    regsOut;
  logic [PTR_W-1:0]                   ptrCur;
  logic                               aiCur;

  i2cBusCtrl #(.ADDR_HI_W(6), .ADDR_HI(ADDR_HI), .SYNC_DEPTH(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrPin(addrPin),
    .rdData(rdData), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  i2cRegFile #(.NUM_PINS(NUM_PINS), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .AI_BIT(4)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .pinsIn(pinsIn), .rdData(rdData),
    .regsOut(regsOut), .ptrCur(ptrCur), .aiCur(aiCur)
  );

  assign prescale0 = regsOut[1];
  assign duty0     = regsOut[2];
  assign prescale1 = regsOut[3];
  assign duty1     = regsOut[4];
  assign ledSelect = regsOut[5];
endmodule

// File: rtl/i2cRegBankChk.sv
module i2cRegBankChk
  import i2cRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input busStrobe_t        strb,
  input logic [2:0]        ptrCur,
  input logic              aiCur,
  input logic [BYTE_W-1:0] prescale0,
  input logic [BYTE_W-1:0] duty0,
  input logic [BYTE_W-1:0] prescale1,
  input logic [BYTE_W-1:0] duty1,
  input logic [BYTE_W-1:0] ledSelect
);
  p_cmd_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdWr |=> (ptrCur == $past(strb.data[2:0])) && (aiCur == $past(strb.data[4])));

  p_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr && ptrCur == 3'd1) |=> prescale0 == $past(strb.data));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.regWr || strb.rdDone) && aiCur && ptrCur == 3'd5) |=> ptrCur == 3'd0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.regWr || strb.rdDone) && !aiCur && !strb.cmdWr) |=> $stable(ptrCur));

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr && (ptrCur == 3'd0 || ptrCur >= 3'd6))
      |=> $stable({prescale0, duty0, prescale1, duty1, ledSelect}));
endmodule

bind i2cRegBank i2cRegBankChk i_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .ptrCur(ptrCur), .aiCur(aiCur),
  .prescale0(prescale0), .duty0(duty0), .prescale1(prescale1),
  .duty1(duty1), .ledSelect(ledSelect)
);

// File: tb/test_i2cRegBank.sv
module test_i2cRegBank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 12;
  localparam int Q = HALF / 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrPin = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] pinsIn = 2'b10;
  logic sdaPullLow;
  logic [7:0] prescale0, duty0, prescale1, duty1, ledSelect;
  wire sdaLine = sdaDrv & ~sdaPullLow;

  int total = 0, bad = 0;
  logic expPull = 1'b0;
  logic monOn = 1'b0;
  logic finished = 1'b0;

  // behavioural reference model
  logic [7:0] mReg [0:7];
  int mPtr = 0;
  bit mAi = 0;
  bit mFirst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cRegBank i_i2cRegBank (
    .clk(clk), .rstN(rstN), .addrPin(addrPin), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .pinsIn(pinsIn), .prescale0(prescale0), .duty0(duty0),
    .prescale1(prescale1), .duty1(duty1), .ledSelect(ledSelect)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mReg[i] = 8'h00;
    mPtr = 0; mAi = 0; mFirst = 0;
  endtask

  task automatic modelStep();
    if (mAi) mPtr = (mPtr >= 5) ? 0 : mPtr + 1;
  endtask

  task automatic modelWrite(input logic [7:0] b);
    if (mFirst) begin
      mPtr = int'(b[2:0]); mAi = b[4]; mFirst = 0;
    end else begin
      if (mPtr >= 1 && mPtr <= 5) mReg[mPtr] = b;
      modelStep();
    end
  endtask

  function automatic logic [7:0] modelRead();
    if (mPtr == 0) return {6'b0, pinsIn};
    if (mPtr <= 5) return mReg[mPtr];
    return 8'h00;
  endfunction

  // per-clock comparison while SCL is high
  always @(negedge clk) begin
    if (monOn && sclDrv && rstN) begin
      check(sdaPullLow == expPull, "R8 monitor sda pull", sdaPullLow, expPull);
      check(prescale0 == mReg[1], "R3 monitor prescale0", prescale0, mReg[1]);
      check(duty0 == mReg[2], "R3 monitor duty0", duty0, mReg[2]);
      check(prescale1 == mReg[3], "R3 monitor prescale1", prescale1, mReg[3]);
      check(duty1 == mReg[4], "R3 monitor duty1", duty1, mReg[4]);
      check(ledSelect == mReg[5], "R3 monitor ledSelect", ledSelect, mReg[5]);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    sdaDrv = 1'b0; waitClk(Q);
    sclDrv = 1'b0; waitClk(1);
  endtask

  task automatic stopCond();
    waitClk(Q); sdaDrv = 1'b0; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    sdaDrv = 1'b1; waitClk(HALF);
  endtask

  task automatic clockBit(input logic b);
    waitClk(Q); sdaDrv = b; waitClk(Q);
    sclDrv = 1'b1; waitClk(HALF);
    sclDrv = 1'b0;
  endtask

  // ninth clock seen from the controller side
  task automatic ackClock(input logic expAck, input string tag);
    waitClk(Q); sdaDrv = 1'b1; expPull = expAck; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    check(sdaPullLow == expAck, tag, sdaPullLow, expAck);
    waitClk(HALF - Q);
    sclDrv = 1'b0; expPull = 1'b0;
  endtask

  task automatic sendAddr(input logic [7:0] a, input logic expAck, input string tag);
    for (int i = 7; i >= 0; i--) clockBit(a[i]);
    ackClock(expAck, tag);
    if (expAck && !a[0]) mFirst = 1;
  endtask

  task automatic writeByte(input logic [7:0] b, input logic live, input string tag);
    for (int i = 7; i >= 0; i--) clockBit(b[i]);
    if (live) modelWrite(b);
    ackClock(live, tag);
  endtask

  task automatic readByte(input logic mack, input string tag);
    logic [7:0] exp, got;
    exp = modelRead();
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q); expPull = ~exp[i]; waitClk(Q);
      sclDrv = 1'b1; waitClk(Q);
      got[i] = sdaLine;
      waitClk(HALF - Q);
      sclDrv = 1'b0;
    end
    modelStep();
    check(got == exp, tag, got, exp);
    waitClk(Q); expPull = 1'b0; sdaDrv = ~mack; waitClk(Q);
    sclDrv = 1'b1; waitClk(HALF);
    sclDrv = 1'b0; waitClk(1);
    sdaDrv = 1'b1;
  endtask

  initial begin
    modelReset();
    waitClk(5);
    check(sdaPullLow == 1'b0, "R9 reset sda released", sdaPullLow, 0);
    check({prescale0, duty0, prescale1, duty1, ledSelect} == 40'h0, "R9 reset registers",
          ledSelect, 0);
    rstN = 1'b1;
    waitClk(5);
    monOn = 1'b1;

    // R1 R2 R3 R4 R6: burst write with auto-advance and wrap
    startCond();
    sendAddr(8'hC0, 1'b1, "R1 address ack write");
    writeByte(8'h11, 1'b1, "R2 command ack");
    writeByte(8'hA1, 1'b1, "R3 ack prescale0");
    writeByte(8'hB2, 1'b1, "R3 ack duty0");
    writeByte(8'hC3, 1'b1, "R3 ack prescale1");
    writeByte(8'hD4, 1'b1, "R3 ack duty1");
    writeByte(8'hE5, 1'b1, "R3 ack ledSelect");
    writeByte(8'h77, 1'b1, "R6 ack write at pointer 0");
    writeByte(8'h5A, 1'b1, "R4 wrapped write to prescale0");
    stopCond();
    check(prescale0 == 8'h5A, "R4 wrap reached prescale0", prescale0, 8'h5A);

    // R5 R4 R7 R8: repeated-start read with auto-advance through wrap
    startCond();
    sendAddr(8'hC0, 1'b1, "R1 address ack");
    writeByte(8'h13, 1'b1, "R2 command ptr3 ai");
    startCond();
    sendAddr(8'hC1, 1'b1, "R8 repeated start read address");
    readByte(1'b1, "R5 read prescale1");
    readByte(1'b1, "R5 read duty1");
    readByte(1'b1, "R5 read ledSelect");
    readByte(1'b1, "R5 read input pins after wrap");
    readByte(1'b0, "R5 read prescale0 last");
    for (int i = 0; i < 9; i++) clockBit(1'b1);
    check(sdaPullLow == 1'b0, "R7 released after nack", sdaPullLow, 0);
    stopCond();

    // R4: no auto-advance keeps the pointer
    startCond();
    sendAddr(8'hC0, 1'b1, "R1 address ack");
    writeByte(8'h04, 1'b1, "R2 command ptr4 no ai");
    writeByte(8'h10, 1'b1, "R4 first write duty1");
    writeByte(8'h20, 1'b1, "R4 second write duty1");
    check(duty1 == 8'h20 && prescale1 == 8'hC3, "R4 pointer held", duty1, 8'h20);
    startCond();
    sendAddr(8'hC1, 1'b1, "R1 read address");
    readByte(1'b1, "R4 read held pointer first");
    readByte(1'b0, "R4 read held pointer second");
    stopCond();

    // R6 R5: pointers 6 and 7
    startCond();
    sendAddr(8'hC0, 1'b1, "R1 address ack");
    writeByte(8'h16, 1'b1, "R2 command ptr6 ai");
    writeByte(8'h99, 1'b1, "R6 write ptr6 ignored");
    writeByte(8'h88, 1'b1, "R6 write ptr0 ignored");
    writeByte(8'h44, 1'b1, "R4 wrap from 6 to prescale0");
    check(prescale0 == 8'h44, "R4 wrap from 6", prescale0, 8'h44);
    startCond();
    sendAddr(8'hC0, 1'b1, "R1 address ack");
    writeByte(8'h07, 1'b1, "R2 command ptr7");
    startCond();
    sendAddr(8'hC1, 1'b1, "R1 read address");
    readByte(1'b0, "R5 ptr7 reads zero");
    stopCond();

    // R1: address mismatch then pin-selected match
    startCond();
    sendAddr(8'hC2, 1'b0, "R1 mismatch no ack");
    writeByte(8'hFF, 1'b0, "R1 ignored after mismatch");
    stopCond();
    addrPin = 1'b1;
    pinsIn = 2'b01;
    waitClk(4);
    startCond();
    sendAddr(8'hC0, 1'b0, "R1 old address now mismatch");
    stopCond();
    startCond();
    sendAddr(8'hC2, 1'b1, "R1 pin-selected address ack");
    writeByte(8'h05, 1'b1, "R2 command ptr5");
    writeByte(8'h3C, 1'b1, "R3 write ledSelect");
    startCond();
    sendAddr(8'hC2, 1'b1, "R8 repeated start write");
    writeByte(8'h00, 1'b1, "R2 command ptr0");
    startCond();
    sendAddr(8'hC3, 1'b1, "R1 read address pin1");
    readByte(1'b0, "R5 input pins 01");
    stopCond();
    check(ledSelect == 8'h3C, "R3 ledSelect value", ledSelect, 8'h3C);

    // R8: STOP mid-transfer then fresh command
    startCond();
    sendAddr(8'hC2, 1'b1, "R1 address ack");
    writeByte(8'h12, 1'b1, "R2 command ptr2 ai");
    stopCond();
    check(sdaPullLow == 1'b0, "R8 stop releases", sdaPullLow, 0);
    startCond();
    sendAddr(8'hC2, 1'b1, "R8 address after stop");
    writeByte(8'h02, 1'b1, "R8 first byte is command again");
    writeByte(8'h6B, 1'b1, "R3 write duty0");
    stopCond();
    check(duty0 == 8'h6B, "R8 duty0 after restart", duty0, 8'h6B);

    // R9: reset in operation
    monOn = 1'b0;
    rstN = 1'b0;
    modelReset();
    waitClk(3);
    check({prescale0, duty0, prescale1, duty1, ledSelect} == 40'h0, "R9 reset clears",
          duty0, 0);
    rstN = 1'b1;
    waitClk(4);
    monOn = 1'b1;
    startCond();
    sendAddr(8'hC2, 1'b1, "R9 address after reset");
    writeByte(8'h01, 1'b1, "R9 command after reset");
    writeByte(8'h2E, 1'b1, "R9 write after reset");
    stopCond();
    check(prescale0 == 8'h2E, "R9 write after reset", prescale0, 8'h2E);

    monOn = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule